// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre Majority Vote

This block receives asynchronous serial frames on a single line. It samples the line only on cycles where an external sample tick is high, and it does not generate that tick itself. In normal mode one bit lasts 16 ticks. In double-speed mode one bit lasts 8 ticks. The line first passes through a two-flop synchroniser. The block then hunts for a falling edge between two consecutive tick samples.

Each start bit is confirmed by a vote over three samples at its centre, so a short low spike is discarded. Every later bit (data, optional parity, first stop bit) takes the majority of the same three centre samples. Bit timing restarts on every accepted start edge.

The frame has 5 to 9 data bits, received least significant bit first, with an optional even or odd parity bit. The frame settings are captured at the start edge. At the end of the stop bit's vote, the block raises a one-cycle valid strobe. In the same cycle it updates the received word and the framing and parity error flags, and these hold their values until the next strobe.

Top module: `uart_mv_rx`

## Requirements
- R1: While reset is low and after its release, `rx_valid` is 0, `rx_data` is 0, and both `frame_err` and `parity_err` are 0 until a frame is received.
- R2: In normal mode (`fast_mode`=0) a bit lasts 16 ticks. Sample 1 is the first tick sample that reads low after a high one. Each bit's value is the majority of its samples 8, 9 and 10. After a frame, `rx_valid` is high for exactly one cycle. At that point `rx_data` holds the data bits with the first received bit in bit 0.
- R3: In double-speed mode (`fast_mode`=1) a bit lasts 8 ticks, and samples 4, 5 and 6 are voted.
- R4: A start edge whose three vote samples are mostly high is dropped without any `rx_valid` strobe. The receiver then hunts for the next falling edge.
- R5: A single inverted sample among a bit's three centre samples does not change that bit's value. Inverted samples outside the three centre samples do not change it either.
- R6: `data_len` gives the number of data bits, from 5 to 9. A value below 5 acts as 5 and a value above 9 acts as 9. Bits of `rx_data` at and above that length read 0.
- R7: With `par_en`=1 a parity bit follows the data. `par_odd`=0 selects even parity, where the XOR of the data and the parity bit is 0. `par_odd`=1 selects odd parity, where that XOR is 1. A mismatch sets `parity_err` for that frame. With `par_en`=0, `parity_err` is 0.
- R8: Only the first stop bit is voted. A voted 0 sets `frame_err` for that frame, and a voted 1 clears it.
- R9: In normal mode the next start edge may fall on sample 11 of the stop bit. In double-speed mode the earliest accepted low sample is sample 8 of the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | Oversampling enable, one cycle per sample |
| rxd | input | 1 | Serial line, idle high |
| fast_mode | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| data_len | input | 4 | Number of data bits (5 to 9) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe at the end of each frame |
| frame_err | output | 1 | Stop bit voted low in the last frame |
| parity_err | output | 1 | Parity mismatch in the last frame |

## Verification
The assertions check on every cycle that the strobe lasts one cycle and follows a tick. They also check that the word and flags change only with the strobe, that bits above the captured length are zero, and that the parity flag stays clear when parity is off. Only the bench scenarios can show the sample positions in action: spikes rejected at the start, noise tolerated inside a bit, the two oversampling rates, length clamping, and the earliest next-start point. These all depend on the waveform over many ticks, which a simple cycle property cannot describe.

// File: rtl/uart_mv_rx_pkg.sv
// Shared types and helpers for the oversampling receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_mv_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    // Two-of-three majority.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_mv_rx_sync.sv
// Multi-flop synchroniser for the asynchronous serial line.
// Assumes: STAGES >= 2; the line idles high, so flops reset to 1.
module uart_mv_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] shift_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '1;
        else        shift_q <= {shift_q[STAGES-2:0], din};
    end

    assign dout = shift_q[STAGES-1];

endmodule

// File: rtl/uart_mv_rx_vote.sv
// Per-bit sample position counter and three-sample centre vote.
// The restart input numbers the current tick as sample 1. While run is high,
// every tick advances the position, which wraps after the last sample of a bit.
// vote_done pulses on the tick of the third centre sample, and vote_val is
// then the majority of the three centre samples.
// Assumes: OSR_NORM and OSR_FAST are even and at least 4; fast is stable per frame.
module uart_mv_rx_vote
    import uart_mv_rx_pkg::*;
#(
    parameter int OSR_NORM = 16,
    parameter int OSR_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    input  logic fast,
    input  logic rx_bit,
    output logic vote_done,
    output logic vote_val
);

    localparam int CW    = $clog2(OSR_NORM + 1);
    localparam int CTR_N = OSR_NORM / 2;
    localparam int CTR_F = OSR_FAST / 2;

    logic [CW-1:0] pos_q, pos_nx, last_pos, first_ctr;
    logic          smp_a_q, smp_b_q;

    // Select the bit length and the first centre position for the active rate.
    always_comb begin
        last_pos  = fast ? CW'(OSR_FAST) : CW'(OSR_NORM);
        first_ctr = fast ? CW'(CTR_F)    : CW'(CTR_N);
        pos_nx    = (pos_q == last_pos) ? CW'(1) : pos_q + CW'(1);
    end

    // Track the sample position and capture the first two centre samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            smp_a_q <= 1'b1;
            smp_b_q <= 1'b1;
        end else if (tick) begin
            if (restart) begin
                pos_q <= CW'(1);
            end else if (run) begin
                pos_q <= pos_nx;
                if (pos_nx == first_ctr)          smp_a_q <= rx_bit;
                if (pos_nx == first_ctr + CW'(1)) smp_b_q <= rx_bit;
            end
        end
    end

    assign vote_done = tick & run & ~restart & (pos_nx == first_ctr + CW'(2));
    assign vote_val  = maj3(smp_a_q, smp_b_q, rx_bit);

endmodule

// File: rtl/uart_mv_rx.sv
// Oversampling serial receiver: start-bit validation, centre majority vote per
// bit, 5..9 data bits (LSB first), optional parity and a single voted stop bit.
// Assumes: sample_tick is at most one cycle wide per sample; the frame settings
// are stable around the start edge (they are captured there).
module uart_mv_rx
    import uart_mv_rx_pkg::*;
#(
    parameter int DATA_MIN    = 5,
    parameter int DATA_MAX    = 9,
    parameter int LEN_W       = 4,
    parameter int OSR_NORM    = 16,
    parameter int OSR_FAST    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                rxd,
    input  logic                fast_mode,
    input  logic [LEN_W-1:0]    data_len,
    input  logic                par_en,
    input  logic                par_odd,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                frame_err,
    output logic                parity_err
);

    rx_state_e            state_q;
    logic                 rx_s, prev_q, fast_q, par_en_q, odd_q, par_bit_q;
    logic [LEN_W-1:0]     len_q, len_eff, bit_idx_q;
    logic [DATA_MAX-1:0]  word_q;
    logic                 start_edge, run, vote_done, vote_val;

    uart_mv_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    // Clamp the requested data length to the supported range.
    always_comb begin
        if (data_len < LEN_W'(DATA_MIN))      len_eff = LEN_W'(DATA_MIN);
        else if (data_len > LEN_W'(DATA_MAX)) len_eff = LEN_W'(DATA_MAX);
        else                                  len_eff = data_len;
    end

    assign start_edge = sample_tick & (state_q == ST_IDLE) & prev_q & ~rx_s;
    assign run        = (state_q == ST_START) | (state_q == ST_DATA) |
                        (state_q == ST_PAR)   | (state_q == ST_STOP);

    uart_mv_rx_vote #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) vote_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .run      (run),
        .restart  (start_edge),
        .fast     (fast_q),
        .rx_bit   (rx_s),
        .vote_done(vote_done),
        .vote_val (vote_val)
    );

    // Frame sequencer: start check, data assembly, parity, stop and result update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            prev_q     <= 1'b1;
            fast_q     <= 1'b0;
            len_q      <= LEN_W'(DATA_MIN);
            par_en_q   <= 1'b0;
            odd_q      <= 1'b0;
            par_bit_q  <= 1'b0;
            bit_idx_q  <= '0;
            word_q     <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample_tick) prev_q <= rx_s;
            case (state_q)
                ST_IDLE: if (start_edge) begin
                    state_q  <= ST_START;
                    fast_q   <= fast_mode;
                    len_q    <= len_eff;
                    par_en_q <= par_en;
                    odd_q    <= par_odd;
                end
                ST_START: if (vote_done) begin
                    bit_idx_q <= '0;
                    word_q    <= '0;
                    state_q   <= vote_val ? ST_IDLE : ST_DATA;
                end
                ST_DATA: if (vote_done) begin
                    word_q[bit_idx_q] <= vote_val;
                    bit_idx_q         <= bit_idx_q + LEN_W'(1);
                    if (bit_idx_q == len_q - LEN_W'(1))
                        state_q <= par_en_q ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (vote_done) begin
                    par_bit_q <= vote_val;
                    state_q   <= ST_STOP;
                end
                ST_STOP: if (vote_done) begin
                    rx_valid   <= 1'b1;
                    rx_data    <= word_q;
                    frame_err  <= ~vote_val;
                    parity_err <= par_en_q & ((^word_q) ^ par_bit_q ^ odd_q);
                    state_q    <= fast_q ? ST_HOLD : ST_IDLE;
                end
                ST_HOLD: if (sample_tick) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_mv_rx_chk.sv
// Property checker for the oversampling receiver, attached by bind.
// Assumes: the bound instance's frame settings are captured in len_q/par_en_q.
module uart_mv_rx_chk #(
    parameter int DATA_MAX = 9,
    parameter int LEN_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_tick,
    input logic                rx_valid,
    input logic [DATA_MAX-1:0] rx_data,
    input logic                frame_err,
    input logic                parity_err,
    input logic [LEN_W-1:0]    len_q,
    input logic                par_en_q
);

    // R2
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sample_tick));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(frame_err) && $stable(parity_err) && $stable(rx_data)));

    // R6
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> len_q) == '0));

    // R7
    no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en_q) |-> !parity_err);

endmodule

bind uart_mv_rx uart_mv_rx_chk #(.DATA_MAX(DATA_MAX), .LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .frame_err  (frame_err),
    .parity_err (parity_err),
    .len_q      (len_q),
    .par_en_q   (par_en_q)
);

// File: tb/uart_mv_rx_tb_top.sv
// Scoreboard bench: the driver serialises frames and queues the expected
// results, and the monitor compares each strobe against the queue.
module uart_mv_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       fast_mode = 1'b0;
    logic [3:0] data_len = 4'd8;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, frame_err, parity_err;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    logic [1:0] tcnt = 2'd0;

    logic [10:0] exp_q[$];   // {data[8:0], fe, pe}
    string       tag_q[$];

    uart_mv_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
        .fast_mode(fast_mode), .data_len(data_len), .par_en(par_en),
        .par_odd(par_odd), .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_err(frame_err), .parity_err(parity_err)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // One sample tick every four clocks, changed away from the active edge.
    always @(negedge clk) begin
        tcnt        <= tcnt + 2'd1;
        sample_tick <= (tcnt == 2'd3);
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Present one line value for the next sample tick.
    task automatic put_sample(input logic v);
        @(negedge clk);
        rxd = v;
        do @(posedge clk); while (!sample_tick);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put_sample(1'b1);
    endtask

    // gmode 1: invert the middle centre sample; 2: invert every non-centre sample.
    task automatic put_bit(input logic v, input int gmode);
        int s;
        logic val;
        s = fast_mode ? 8 : 16;
        for (int k = 1; k <= s; k++) begin
            val = v;
            if (gmode == 1 && k == s / 2 + 1) val = ~v;
            if (gmode == 2 && (k < s / 2 || k > s / 2 + 2)) val = ~v;
            put_sample(val);
        end
    endtask

    task automatic send_frame(input string tag, input logic [8:0] d, input int gidx,
                              input int gmode, input logic bad_par, input logic stop_v,
                              input logic short_stop);
        int   leff;
        logic [8:0] dm;
        logic pbit;
        leff = (data_len < 5) ? 5 : (data_len > 9) ? 9 : int'(data_len);
        dm   = d & 9'((1 << leff) - 1);
        pbit = (^dm) ^ par_odd ^ bad_par;
        exp_q.push_back({dm, ~stop_v, par_en & bad_par});
        tag_q.push_back(tag);
        put_bit(1'b0, 0);
        for (int i = 0; i < leff; i++) put_bit(dm[i], (i == gidx) ? gmode : 0);
        if (par_en) put_bit(pbit, 0);
        if (short_stop) begin
            for (int k = 0; k < (fast_mode ? 7 : 10); k++) put_sample(stop_v);
        end else begin
            put_bit(stop_v, 0);
        end
    endtask

    // Monitor: compare each strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            n_valid++;
            if (exp_q.size() == 0) begin
                chk("R4", "unexpected frame", 1, 0);
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "data", int'(rx_data), int'(e[10:2]));
                chk(t, "frame_err", int'(frame_err), int'(e[1]));
                chk(t, "parity_err", int'(parity_err), int'(e[0]));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v0;
        repeat (5) @(negedge clk);
        // R1: outputs quiet in and after reset
        chk("R1", "valid in reset", int'(rx_valid), 0);
        chk("R1", "data in reset", int'(rx_data), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(20);
        chk("R1", "valid after reset", int'(rx_valid), 0);
        chk("R1", "flags after reset", int'({frame_err, parity_err}), 0);
        chk("R1", "data after reset", int'(rx_data), 0);

        // R2: normal rate, 8 bits, several patterns
        send_frame("R2", 9'h0A5, -1, 0, 0, 1, 0); idle(6);
        send_frame("R2", 9'h03C, -1, 0, 0, 1, 0); idle(6);
        send_frame("R2", 9'h0FF, -1, 0, 0, 1, 0); idle(6);

        // R3: double-speed rate
        fast_mode = 1'b1;
        send_frame("R3", 9'h05A, -1, 0, 0, 1, 0); idle(4);
        send_frame("R3", 9'h081, -1, 0, 0, 1, 0); idle(4);
        fast_mode = 1'b0;

        // R6: lengths and clamping
        data_len = 4'd5;  send_frame("R6", 9'h1F3, -1, 0, 0, 1, 0); idle(6);
        data_len = 4'd9;  send_frame("R6", 9'h1A7, -1, 0, 0, 1, 0); idle(6);
        data_len = 4'd3;  send_frame("R6", 9'h0EE, -1, 0, 0, 1, 0); idle(6);
        data_len = 4'd15; send_frame("R6", 9'h155, -1, 0, 0, 1, 0); idle(6);
        data_len = 4'd8;

        // R7: parity even/odd, good and bad
        par_en = 1'b1;
        par_odd = 1'b0; send_frame("R7", 9'h0B3, -1, 0, 0, 1, 0); idle(6);
        par_odd = 1'b1; send_frame("R7", 9'h0B3, -1, 0, 0, 1, 0); idle(6);
        par_odd = 1'b0; send_frame("R7", 9'h071, -1, 0, 1, 1, 0); idle(6);
        fast_mode = 1'b1;
        par_odd = 1'b1; send_frame("R7", 9'h071, -1, 0, 1, 1, 0); idle(6);
        fast_mode = 1'b0; par_en = 1'b0; par_odd = 1'b0;

        // R8: stop bit low, then a clean frame clears the flag
        send_frame("R8", 9'h042, -1, 0, 0, 0, 0); idle(20);
        send_frame("R8", 9'h043, -1, 0, 0, 1, 0); idle(6);

        // R5: noise inside a bit
        send_frame("R5", 9'h0C6, 2, 1, 0, 1, 0); idle(6);
        send_frame("R5", 9'h0C6, 5, 2, 0, 1, 0); idle(6);
        fast_mode = 1'b1;
        send_frame("R5", 9'h039, 0, 1, 0, 1, 0); idle(6);
        send_frame("R5", 9'h039, 7, 2, 0, 1, 0); idle(6);
        fast_mode = 1'b0;

        // R4: start spikes are dropped with no strobe
        v0 = n_valid;
        for (int k = 0; k < 7; k++) put_sample(1'b0);
        idle(40);
        chk("R4", "strobes after normal spike", n_valid - v0, 0);
        fast_mode = 1'b1;
        for (int k = 0; k < 3; k++) put_sample(1'b0);
        idle(24);
        chk("R4", "strobes after fast spike", n_valid - v0, 0);
        send_frame("R4", 9'h066, -1, 0, 0, 1, 0); idle(6);
        fast_mode = 1'b0;

        // R9: earliest next start after a shortened stop bit
        send_frame("R9", 9'h011, -1, 0, 0, 1, 1);
        send_frame("R9", 9'h0EE, -1, 0, 0, 1, 0); idle(6);
        fast_mode = 1'b1;
        send_frame("R9", 9'h022, -1, 0, 0, 1, 1);
        send_frame("R9", 9'h0DD, -1, 0, 0, 1, 0); idle(6);
        fast_mode = 1'b0;

        idle(10);
        chk("R2", "frames still pending", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule